// File: doc/BRIEF.md
# Load/Store Request Staging Buffer

This block stands between an issue stage and a pair of execution units: one unit handles loads and the other handles stores. The issuer hands over a packed request made of a valid bit, a virtual address, an operand, byte enables, a unit selector, an operator code and a transaction tag. The block drives a single control word that both units see. Each unit checks the unit selector to decide whether the word is meant for it.

A request is passed straight through when no older work is waiting and the target unit says it is ready. In every other case the request goes into a two-slot first-in first-out store. The oldest stored request stays on the output, unchanged, until the unit it targets retires it with that unit's pop strobe. A ready signal back to the issuer shows whether a slot is free. There is one exception to that rule: when the store is full, a new request is still taken in the same cycle that a matching pop frees a slot.

Top module: `lsu_req_stager`

## Requirements
- R1: Reset is synchronous and active-high. In the first cycle after reset is released, with no request presented, `out_valid` is 0, `in_ready` is 1 and nothing is stored.
- R2: A request passes through in the cycle it is presented, with `out_valid` = 1 and every field equal to the input. This happens when all of the following hold: nothing is stored, `in_valid` is 1, and the target unit is ready (unit code 2'b01 selects the load unit and its `ld_ready`; unit code 2'b10 selects the store unit and its `st_ready`). A passed-through request is not stored.
- R3: Any other request with `in_valid` = 1 is stored if a slot is free. From the next cycle on, the oldest stored request is driven on the output with `out_valid` = 1.
- R4: A stored request on the output does not change in any field while it has not been retired. New arrivals and changes on `ld_ready` or `st_ready` do not affect it.
- R5: `pop_ld` retires the stored head only when the head has unit code 2'b01. `pop_st` retires it only when the head has unit code 2'b10. A pop that does not match the head's unit is ignored. After a retire, the next stored request, or nothing, shows from the following cycle.
- R6: `in_ready` is 0 exactly when both slots hold a request, and 1 otherwise.
- R7: A request presented while both slots are full and no matching pop occurs is discarded. It never appears on the output.
- R8: When both slots are full, a matching pop and a new request in the same cycle retire the head and store the new request. The store stays full and the order is kept.
- R9: Stored requests leave in the order they arrived.
- R10: A pop of either kind while nothing is stored has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_vaddr | input | 64 | Request virtual address |
| in_operand | input | 64 | Request operand |
| in_be | input | 8 | Request byte enables |
| in_unit | input | 2 | Target unit: 2'b01 load, 2'b10 store |
| in_op | input | 4 | Operator code |
| in_tid | input | 3 | Transaction tag |
| ld_ready | input | 1 | Load unit can take a request this cycle |
| st_ready | input | 1 | Store unit can take a request this cycle |
| pop_ld | input | 1 | Load unit retires the stored head |
| pop_st | input | 1 | Store unit retires the stored head |
| in_ready | output | 1 | A storage slot is free |
| out_valid | output | 1 | Control word is valid |
| out_vaddr | output | 64 | Applied virtual address |
| out_operand | output | 64 | Applied operand |
| out_be | output | 8 | Applied byte enables |
| out_unit | output | 2 | Applied target unit |
| out_op | output | 4 | Applied operator code |
| out_tid | output | 3 | Applied transaction tag |

## Verification
The hardest case to reach from the ports is the full-store cycle where a matching pop and a new request arrive together. `in_ready` is already low at that point, so a well-behaved issuer would never send a request then. The stimulus reaches this case in two steps. First it parks two requests behind a unit that is held not ready. Then it deliberately drives a request against the low ready in the same cycle as the matching pop. A second hard case is the mismatched pop. The stimulus places a load at the head, pulses only `pop_st` for several cycles, and checks that the word holds. After that it runs a long mixed stretch of random ready, pop and request patterns against a queue model.

// File: rtl/lsu_stage_pkg.sv
package lsu_stage_pkg;

    localparam int VADDR_W = 64;
    localparam int OPND_W  = 64;
    localparam int BE_W    = OPND_W / 8;
    localparam int OP_W    = 4;
    localparam int TID_W   = 3;

    typedef enum logic [1:0] {
        UNIT_NONE  = 2'b00,
        UNIT_LOAD  = 2'b01,
        UNIT_STORE = 2'b10
    } unit_e;

    typedef struct packed {
        logic               valid;
        logic [VADDR_W-1:0] vaddr;
        logic [OPND_W-1:0]  operand;
        logic [BE_W-1:0]    be;
        unit_e              unit;
        logic [OP_W-1:0]    op;
        logic [TID_W-1:0]   tid;
    } stage_req_t;

    // target unit of a request is able to take it now
    function automatic logic unit_can_take(unit_e u, logic ld_rdy, logic st_rdy);
        case (u)
            UNIT_LOAD:  return ld_rdy;
            UNIT_STORE: return st_rdy;
            default:    return 1'b0;
        endcase
    endfunction

    // a pop strobe matches the unit of the stored head
    function automatic logic unit_retires(unit_e u, logic pop_ld, logic pop_st);
        case (u)
            UNIT_LOAD:  return pop_ld;
            UNIT_STORE: return pop_st;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_stage_fifo.sv
module lsu_stage_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    // a write into a full store must be paired with a retire (R7, R8)
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |-> rd_en);

    // pops on an empty store never reach the storage (R10)
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

    // reset leaves the store empty (R1)
    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> empty);

    // head word unchanged while not read (R4)
    assert_head_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!empty && !rd_en) |=> $stable(rd_data));

endmodule

// File: rtl/lsu_stage_steer.sv
module lsu_stage_steer
    import lsu_stage_pkg::*;
(
    input  stage_req_t in_req,
    input  stage_req_t head,
    input  logic       fifo_empty,
    input  logic       fifo_full,
    input  logic       ld_ready,
    input  logic       st_ready,
    input  logic       pop_ld,
    input  logic       pop_st,
    output logic       bypass,
    output logic       push,
    output logic       retire,
    output logic       in_ready,
    output stage_req_t out_req
);

    always_comb begin
        bypass   = fifo_empty && in_req.valid
                 && unit_can_take(in_req.unit, ld_ready, st_ready);
        retire   = !fifo_empty && unit_retires(head.unit, pop_ld, pop_st);
        push     = in_req.valid && !bypass && (!fifo_full || retire);
        in_ready = !fifo_full;

        if (!fifo_empty) begin
            out_req       = head;
            out_req.valid = 1'b1;
        end else if (bypass) begin
            out_req = in_req;
        end else begin
            out_req = '0;
        end
    end

endmodule

// File: rtl/lsu_req_stager.sv
module lsu_req_stager
    import lsu_stage_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VADDR_W-1:0] in_vaddr,
    input  logic [OPND_W-1:0]  in_operand,
    input  logic [BE_W-1:0]    in_be,
    input  logic [1:0]         in_unit,
    input  logic [OP_W-1:0]    in_op,
    input  logic [TID_W-1:0]   in_tid,
    input  logic               ld_ready,
    input  logic               st_ready,
    input  logic               pop_ld,
    input  logic               pop_st,
    output logic               in_ready,
    output logic               out_valid,
    output logic [VADDR_W-1:0] out_vaddr,
    output logic [OPND_W-1:0]  out_operand,
    output logic [BE_W-1:0]    out_be,
    output logic [1:0]         out_unit,
    output logic [OP_W-1:0]    out_op,
    output logic [TID_W-1:0]   out_tid
);

    localparam int REQ_W = $bits(stage_req_t);

    stage_req_t in_req, head, out_req;
    logic [REQ_W-1:0] head_bits;
    logic fifo_empty, fifo_full, bypass, push, retire;

    always_comb begin
        in_req.valid   = in_valid;
        in_req.vaddr   = in_vaddr;
        in_req.operand = in_operand;
        in_req.be      = in_be;
        in_req.unit    = unit_e'(in_unit);
        in_req.op      = in_op;
        in_req.tid     = in_tid;
    end

    assign head = stage_req_t'(head_bits);

    lsu_stage_fifo #(
        .W     (REQ_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_data (in_req),
        .rd_en   (retire),
        .rd_data (head_bits),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    lsu_stage_steer u_steer (
        .in_req     (in_req),
        .head       (head),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .ld_ready   (ld_ready),
        .st_ready   (st_ready),
        .pop_ld     (pop_ld),
        .pop_st     (pop_st),
        .bypass     (bypass),
        .push       (push),
        .retire     (retire),
        .in_ready   (in_ready),
        .out_req    (out_req)
    );

    assign out_valid   = out_req.valid;
    assign out_vaddr   = out_req.vaddr;
    assign out_operand = out_req.operand;
    assign out_be      = out_req.be;
    assign out_unit    = out_req.unit;
    assign out_op      = out_req.op;
    assign out_tid     = out_req.tid;

    // applied word holds while the stored head is not retired (R4)
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!fifo_empty && !retire) |=> (out_valid && $stable(out_req)));

    // issuer stalled only while a stored request is being applied (R6)
    assert_stall_has_work_R6: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

    // a store pop never moves a load head (R5)
    assert_pop_mismatch_R5: assert property (@(posedge clk) disable iff (rst)
        (!fifo_empty && out_unit == UNIT_LOAD && pop_st && !pop_ld)
        |=> (out_valid && $stable(out_tid) && $stable(out_vaddr)));

    // with nothing stored the output mirrors the incoming request (R2)
    assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && out_valid) |-> (out_tid == in_tid && out_vaddr == in_vaddr));

    // full + retire + new request keeps the store full (R8)
    assert_swap_full_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && retire && in_valid) |=> !in_ready);

endmodule

// File: tb/lsu_req_stager_tb.sv
module lsu_req_stager_tb;

    typedef struct {
        logic [63:0] va;
        logic [63:0] opd;
        logic [7:0]  be;
        logic [1:0]  u;
        logic [3:0]  op;
        logic [2:0]  tid;
    } item_t;

    localparam logic [1:0] LD = 2'b01;
    localparam logic [1:0] ST = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        in_valid = 0;
    logic [63:0] in_vaddr = '0;
    logic [63:0] in_operand = '0;
    logic [7:0]  in_be = '0;
    logic [1:0]  in_unit = '0;
    logic [3:0]  in_op = '0;
    logic [2:0]  in_tid = '0;
    logic ld_ready = 0, st_ready = 0, pop_ld = 0, pop_st = 0;
    logic        in_ready, out_valid;
    logic [63:0] out_vaddr, out_operand;
    logic [7:0]  out_be;
    logic [1:0]  out_unit;
    logic [3:0]  out_op;
    logic [2:0]  out_tid;

    lsu_req_stager u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vaddr(in_vaddr),
        .in_operand(in_operand), .in_be(in_be), .in_unit(in_unit), .in_op(in_op),
        .in_tid(in_tid), .ld_ready(ld_ready), .st_ready(st_ready),
        .pop_ld(pop_ld), .pop_st(pop_st), .in_ready(in_ready),
        .out_valid(out_valid), .out_vaddr(out_vaddr), .out_operand(out_operand),
        .out_be(out_be), .out_unit(out_unit), .out_op(out_op), .out_tid(out_tid)
    );

    item_t exp_q[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;
    int serial = 0;

    function automatic item_t mk(logic [1:0] u);
        item_t it;
        serial++;
        it.tid = 3'(serial);
        it.u   = u;
        it.va  = 64'h1000_0000_0000_0000 + 64'(serial) * 64'h10_0008;
        it.opd = {32'hA5A5_0000 + 32'(serial), 32'(serial) ^ 32'h5A5A_5A5A};
        it.be  = 8'(serial * 7);
        it.op  = 4'(serial * 3);
        return it;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver + monitor for one cycle; the model queue holds the expected stored items
    task automatic cycle(string tag, logic v, item_t it, logic lr, logic sr, logic pl, logic ps);
        bit empty, tr, byp, popok, push;
        @(negedge clk);
        in_valid = v; in_vaddr = it.va; in_operand = it.opd; in_be = it.be;
        in_unit = it.u; in_op = it.op; in_tid = it.tid;
        ld_ready = lr; st_ready = sr; pop_ld = pl; pop_st = ps;
        #2;
        empty = (exp_q.size() == 0);
        tr    = (it.u == LD) ? lr : (it.u == ST) ? sr : 1'b0;
        byp   = empty && v && tr;
        chk(in_ready == (exp_q.size() < 2), {tag, "/R6"}, "in_ready",
            64'(in_ready), 64'(exp_q.size() < 2));
        if (!empty) begin
            chk(out_valid && {out_vaddr, out_operand, out_be, out_unit, out_op, out_tid}
                == {exp_q[0].va, exp_q[0].opd, exp_q[0].be, exp_q[0].u, exp_q[0].op, exp_q[0].tid},
                {tag, "/R4"}, "stored head tid", 64'(out_tid), 64'(exp_q[0].tid));
        end else if (byp) begin
            chk(out_valid && {out_vaddr, out_operand, out_be, out_unit, out_op, out_tid}
                == {it.va, it.opd, it.be, it.u, it.op, it.tid},
                {tag, "/R2"}, "pass-through tid", 64'(out_tid), 64'(it.tid));
        end else begin
            chk(!out_valid, tag, "out_valid idle", 64'(out_valid), 64'd0);
        end
        popok = !empty && ((exp_q[0].u == LD && pl) || (exp_q[0].u == ST && ps));
        push  = v && !byp && (exp_q.size() < 2 || popok);
        if (popok) void'(exp_q.pop_front());
        if (push)  exp_q.push_back(it);
    endtask

    task automatic idle(string tag, logic lr, logic sr, logic pl, logic ps);
        item_t z;
        z = '{default: '0};
        cycle(tag, 1'b0, z, lr, sr, pl, ps);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        item_t a, b, c, d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        idle("R1", 0, 0, 0, 0);

        // R2: pass-through for load and store, not stored afterwards
        cycle("R2", 1, mk(LD), 1, 0, 0, 0);
        idle("R2", 1, 1, 0, 0);
        cycle("R2", 1, mk(ST), 0, 1, 0, 0);
        idle("R2", 0, 0, 0, 0);

        // R3: target not ready, stored and applied next cycle
        cycle("R3", 1, mk(LD), 0, 1, 0, 0);
        idle("R3", 0, 0, 0, 0);

        // R4: new arrival and ready toggling do not disturb the head
        cycle("R4", 1, mk(ST), 1, 1, 0, 0);
        idle("R4", 1, 0, 0, 0);
        idle("R4", 0, 1, 0, 0);

        // R5: store pop on load head ignored, then matching pop retires
        idle("R5", 0, 0, 0, 1);
        idle("R5", 0, 0, 0, 1);
        idle("R5", 0, 0, 1, 0);
        idle("R5", 0, 0, 1, 0);   // head now store: load pop ignored
        idle("R5", 0, 0, 0, 1);
        idle("R5", 0, 0, 0, 0);

        // R6, R7: fill, discard while full, drain and confirm the discarded one never shows
        a = mk(LD); b = mk(ST); c = mk(LD);
        cycle("R6", 1, a, 0, 0, 0, 0);
        cycle("R6", 1, b, 0, 0, 0, 0);
        cycle("R7", 1, c, 1, 1, 0, 0);
        idle("R7", 0, 0, 1, 0);
        idle("R7", 0, 0, 0, 1);
        idle("R7", 0, 0, 0, 0);

        // R8: full + matching pop + new request
        a = mk(ST); b = mk(LD); d = mk(ST);
        cycle("R8", 1, a, 0, 0, 0, 0);
        cycle("R8", 1, b, 0, 0, 0, 0);
        cycle("R8", 1, d, 0, 0, 0, 1);
        idle("R8", 0, 0, 1, 0);
        idle("R9", 0, 0, 0, 1);
        idle("R9", 0, 0, 0, 0);

        // R10: pops on empty store
        idle("R10", 0, 0, 1, 1);
        idle("R10", 0, 0, 1, 0);
        cycle("R10", 1, mk(ST), 0, 0, 1, 1);
        idle("R10", 0, 0, 0, 1);

        // R9: long mixed sequence in arrival order
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle("R9", r[0], mk(r[1] ? ST : LD), r[2], r[3], r[4], r[5]);
        end
        for (int i = 0; i < 4; i++) idle("R9", 0, 0, 1, 1);
        idle("R9", 0, 0, 0, 0);

        finish_run();
    end

endmodule